// File: doc/BRIEF.md
# Double-Buffered Serial Shift Output

This block turns 16-bit words into a serial bit stream on one output pin and drives a matching shift clock on a second pin, both generated from the core clock. Words are written through a simple register-style port into one of two shadow buffers. The buffers are drained in strict alternation, so the host can fill one while the other is being shifted out.

A word is sent most significant bit first. Each bit lasts a programmable number of core cycles. The data pin changes while the shift clock is low, so a receiver can sample it on the rising edge. When one buffer finishes and the other already holds a word, the next word starts on the following cycle with no break in the clock.

Each buffer has an empty flag. The host writes a buffer only while its flag is set. When nothing is pending, the clock pin rests low and the data pin keeps the last bit sent.

Top module: `ssout_top`

## Requirements
- R1: After reset both empty flags read 1 (bit 0 for buffer 0, bit 1 for buffer 1), and both output pins read 0 (`gpo_out[0]` is data, `gpo_out[1]` is the shift clock).
- R2: When `wr_en` is high at a clock edge, `wr_data` is stored in buffer `wr_sel`, and that buffer's empty flag reads 0 from the next cycle.
- R3: After reset the buffers are drained in strict alternation starting with buffer 0. Each word leaves MSB first, one bit per shift-clock period.
- R4: Let D be `div_ratio` sampled when a word is loaded, with 0 and 1 treated as 2. Each bit lasts D core cycles: the clock is low for the first floor(D/2) cycles and high for the rest. Rising edges inside a word are therefore D cycles apart.
- R5: The data pin changes only while the clock pin is low, so it is stable at every rising edge.
- R6: A word written into an idle block sets its buffer's empty flag exactly 16*D+1 cycles after the write edge. The flag still reads 0 one cycle earlier.
- R7: If the other buffer holds a word when the current word's last bit ends, its first bit starts on the next cycle. The spacing between the last rising edge of the old word and the first rising edge of the new word is (Dold - floor(Dold/2)) + floor(Dnew/2).
- R8: When no word is shifting, the clock pin is held low and the data pin holds the last bit sent.
- R9: A change of `div_ratio` during a word does not alter that word's timing. It takes effect at the next word load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a shadow buffer |
| wr_sel | input | 1 | Index of the buffer being written |
| wr_data | input | 16 | Word to store |
| div_ratio | input | 8 | Core cycles per bit; values below 2 act as 2 |
| buf_empty | output | 2 | Per-buffer empty flags |
| gpo_out | output | 2 | Bit 0 is serial data, bit 1 is the shift clock |

## Verification
Each result falls due at a fixed distance from its stimulus:
- **Empty flag after a write:** it is checked at the falling edge after the write edge.
- **First rising edge of a word started from idle:** it appears floor(D/2) cycles after the load edge, and the load edge is one cycle after the write.
- **Rising edges inside a word:** they follow every D cycles.
- **Empty flag of a finished word:** it sets on edge 16*D+1 after the write. The bench samples one cycle before and at that edge.

The scoreboard queues each expected bit together with the interval that must precede its rising edge. The interval is computed from the R4 and R7 formulas using the divider the bench knows will be latched. A monitor samples at falling edges, finds rising edges of the shift clock, and compares data, data stability and edge spacing there.

// File: rtl/ssout_pkg.sv
package ssout_pkg;

    localparam int unsigned SSO_WORD_W = 16;
    localparam int unsigned SSO_NBUF   = 2;
    localparam int unsigned SSO_DIV_W  = 8;
    localparam int unsigned SSO_MIN_DIV = 2;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_SHIFT = 1'b1
    } seq_mode_t;

    // Next buffer index in the ring of n buffers.
    function automatic int unsigned ring_next(input int unsigned p, input int unsigned n);
        return (p + 1 == n) ? 0 : p + 1;
    endfunction

    // Enforce the minimum bit length in core cycles.
    function automatic int unsigned clamp_div(input int unsigned d);
        return (d < SSO_MIN_DIV) ? SSO_MIN_DIV : d;
    endfunction

endpackage

// File: rtl/ssout_shadow.sv
module ssout_shadow #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned NBUF   = 2,
    localparam int unsigned PTR_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              done,
    input  logic [PTR_W-1:0]  done_idx,
    output logic [WORD_W-1:0] words [NBUF],
    output logic [NBUF-1:0]   empty
);

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        logic hit_wr;
        logic hit_done;

        assign hit_wr   = wr_en && (wr_sel == PTR_W'(g));
        assign hit_done = done && (done_idx == PTR_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
                empty[g] <= 1'b1;
            end else if (hit_wr) begin
                // a write wins over a completion in the same cycle
                words[g] <= wr_data;
                empty[g] <= 1'b0;
            end else if (hit_done) begin
                empty[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ssout_bitclk.sv
module ssout_bitclk #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             load,
    input  logic [DIV_W-1:0] div_q,
    output logic             bit_end,
    output logic             clk_hi
);

    logic [DIV_W-1:0] phase;
    logic [DIV_W-1:0] half;

    assign half    = div_q >> 1;
    assign bit_end = busy && (phase == div_q - DIV_W'(1));
    assign clk_hi  = busy && (phase >= half);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (load || bit_end || !busy) begin
            phase <= '0;
        end else begin
            phase <= phase + DIV_W'(1);
        end
    end

endmodule

// File: rtl/ssout_seq.sv
module ssout_seq
    import ssout_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned NBUF   = 2,
    parameter int unsigned DIV_W  = 8,
    localparam int unsigned PTR_W = (NBUF > 1) ? $clog2(NBUF) : 1,
    localparam int unsigned CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [NBUF-1:0]   empty,
    input  logic [WORD_W-1:0] words [NBUF],
    input  logic              bit_end,
    output logic              busy,
    output logic              load,
    output logic [DIV_W-1:0]  div_q,
    output logic              done,
    output logic [PTR_W-1:0]  done_idx,
    output logic              dout
);

    seq_mode_t         mode;
    logic [PTR_W-1:0]  act;
    logic [PTR_W-1:0]  nxt;
    logic [PTR_W-1:0]  load_idx;
    logic [CNT_W-1:0]  bitidx;
    logic [WORD_W-1:0] sh;
    logic              start_idle;
    logic              chain;

    assign busy       = (mode == SEQ_SHIFT);
    assign nxt        = PTR_W'(ring_next(32'(act), NBUF));
    assign done       = bit_end && (bitidx == CNT_W'(WORD_W - 1));
    assign done_idx   = act;
    assign start_idle = !busy && !empty[act];
    assign chain      = done && !empty[nxt];
    assign load       = start_idle || chain;
    assign load_idx   = busy ? nxt : act;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= SEQ_IDLE;
            act    <= '0;
            bitidx <= '0;
            sh     <= '0;
            dout   <= 1'b0;
            div_q  <= DIV_W'(SSO_MIN_DIV);
        end else if (load) begin
            mode   <= SEQ_SHIFT;
            act    <= load_idx;
            bitidx <= '0;
            sh     <= words[load_idx];
            dout   <= words[load_idx][WORD_W-1];
            div_q  <= DIV_W'(clamp_div(32'(div_in)));
        end else if (done) begin
            mode   <= SEQ_IDLE;
            act    <= nxt;
        end else if (bit_end) begin
            bitidx <= bitidx + CNT_W'(1);
            sh     <= {sh[WORD_W-2:0], 1'b0};
            dout   <= sh[WORD_W-2];
        end
    end

endmodule

// File: rtl/ssout_top.sv
module ssout_top
    import ssout_pkg::*;
#(
    parameter int unsigned WORD_W = SSO_WORD_W,
    parameter int unsigned NBUF   = SSO_NBUF,
    parameter int unsigned DIV_W  = SSO_DIV_W,
    localparam int unsigned PTR_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  div_ratio,
    output logic [NBUF-1:0]   buf_empty,
    output logic [1:0]        gpo_out
);

    logic [WORD_W-1:0] words [NBUF];
    logic              busy;
    logic              load;
    logic              done;
    logic [PTR_W-1:0]  done_idx;
    logic [DIV_W-1:0]  div_q;
    logic              bit_end;
    logic              clk_hi;
    logic              dout;

    ssout_shadow #(.WORD_W(WORD_W), .NBUF(NBUF)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .done     (done),
        .done_idx (done_idx),
        .words    (words),
        .empty    (buf_empty)
    );

    ssout_seq #(.WORD_W(WORD_W), .NBUF(NBUF), .DIV_W(DIV_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .div_in   (div_ratio),
        .empty    (buf_empty),
        .words    (words),
        .bit_end  (bit_end),
        .busy     (busy),
        .load     (load),
        .div_q    (div_q),
        .done     (done),
        .done_idx (done_idx),
        .dout     (dout)
    );

    ssout_bitclk #(.DIV_W(DIV_W)) u_bitclk (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .load    (load),
        .div_q   (div_q),
        .bit_end (bit_end),
        .clk_hi  (clk_hi)
    );

    // pin 0 carries data, pin 1 carries the shift clock
    assign gpo_out = {clk_hi, dout};

endmodule

// File: rtl/ssout_sva.sv
module ssout_sva #(
    parameter int unsigned NBUF = 2,
    localparam int unsigned PTR_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [PTR_W-1:0] wr_sel,
    input logic [NBUF-1:0]  buf_empty,
    input logic [1:0]       gpo_out
);

    // R2: a written buffer is non-empty in the next cycle
    p_write_clears_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !buf_empty[$past(wr_sel)]);

    // R5: data is stable across each rising edge of the shift clock
    p_data_stable_at_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(gpo_out[1]) |-> $stable(gpo_out[0]));

    // R5: data moves only while the shift clock is low
    p_data_moves_low_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(gpo_out[0]) |-> !gpo_out[1]);

    // R8: with every buffer empty the clock rests low
    p_clk_low_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (&buf_empty) |-> !gpo_out[1]);

    // R8: with every buffer empty the data pin holds through the next cycle
    p_data_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (&buf_empty) |=> $stable(gpo_out[0]));

    // R3: at most one buffer completes per cycle
    p_single_done_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(buf_empty & ~$past(buf_empty)) <= 1);

endmodule

bind ssout_top ssout_sva #(.NBUF(NBUF)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .buf_empty (buf_empty),
    .gpo_out   (gpo_out)
);

// File: tb/ssout_top_tb_top.sv
`timescale 1ns/1ps
module ssout_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  div_ratio = 8'd4;
    logic [1:0]  buf_empty;
    logic [1:0]  gpo_out;

    always #2 clk = ~clk;   // 250 MHz

    ssout_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .div_ratio (div_ratio),
        .buf_empty (buf_empty),
        .gpo_out   (gpo_out)
    );

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;
    int unsigned last_rise = 0;
    bit          prev_clk = 1'b0;
    bit          prev_data = 1'b0;
    bit          done_flag = 1'b0;

    // scoreboard queues
    bit          exp_bit_q [$];
    int unsigned exp_int_q [$];
    string       exp_tag_q [$];

    logic [0:0]  nsel = '0;
    int unsigned prev_div = 2;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: find rising shift-clock edges at falling core-clock edges
    always @(negedge clk) begin
        if (!rst) begin
            if (gpo_out[1] && !prev_clk) begin
                if (exp_bit_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected shift edge", 1, 0);
                end else begin
                    bit          eb;
                    int unsigned ei;
                    string       et;
                    eb = exp_bit_q.pop_front();
                    ei = exp_int_q.pop_front();
                    et = exp_tag_q.pop_front();
                    chk(gpo_out[0] == eb, "R3", "serial bit", int'(gpo_out[0]), int'(eb));
                    chk(gpo_out[0] == prev_data, "R5", "data stable at rise",
                        int'(gpo_out[0]), int'(prev_data));
                    if (ei != 0)
                        chk(cyc - last_rise == ei, et, "edge spacing",
                            int'(cyc - last_rise), int'(ei));
                end
                last_rise = cyc;
            end
        end
        prev_clk  = gpo_out[1];
        prev_data = gpo_out[0];
    end

    // driver: write the next buffer in turn and queue its expected bits
    task automatic send(input logic [15:0] w, input int unsigned dexp, input string tag);
        bit contig;
        while (buf_empty[nsel] == 1'b0) @(negedge clk);
        contig = (buf_empty[~nsel] == 1'b0);
        for (int i = 15; i >= 0; i--) begin
            exp_bit_q.push_back(w[i]);
            if (i == 15) begin
                exp_int_q.push_back(contig ? (prev_div - prev_div / 2) + dexp / 2 : 0);
                exp_tag_q.push_back("R7");
            end else begin
                exp_int_q.push_back(dexp);
                exp_tag_q.push_back(tag);
            end
        end
        prev_div = dexp;
        wr_en   = 1'b1;
        wr_sel  = nsel;
        wr_data = w;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk(buf_empty[nsel] == 1'b0, "R2", "empty flag after write",
            int'(buf_empty[nsel]), 0);
        nsel = ~nsel;
    endtask

    task automatic drain();
        int unsigned t = 0;
        while ((exp_bit_q.size() != 0 || buf_empty != 2'b11) && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 5000, "R3", "stream drained", int'(exp_bit_q.size()), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic idle_hold(input bit lastbit);
        int unsigned bad = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (gpo_out[1] != 1'b0 || gpo_out[0] != lastbit) bad++;
        end
        chk(bad == 0, "R8", "idle pins hold", int'(bad), 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(buf_empty == 2'b11, "R1", "empty flags", int'(buf_empty), 3);
        chk(gpo_out == 2'b00, "R1", "output pins", int'(gpo_out), 0);

        // R6: single word from idle, D=4
        div_ratio = 8'd4;
        send(16'hA5C3, 4, "R4");
        repeat (64) @(posedge clk);
        @(negedge clk);
        chk(buf_empty[0] == 1'b0, "R6", "flag one cycle early", int'(buf_empty[0]), 0);
        @(posedge clk);
        @(negedge clk);
        chk(buf_empty[0] == 1'b1, "R6", "flag at 16*D+1", int'(buf_empty[0]), 1);
        drain();
        idle_hold(1'b1);   // R8: last bit of A5C3 is 1

        // R7: continuous stream at D=2, alternating buffers
        div_ratio = 8'd2;
        send(16'h1234, 2, "R4");
        send(16'hFEDC, 2, "R4");
        send(16'h8001, 2, "R4");
        send(16'h7FFE, 2, "R4");
        send(16'h0F0F, 2, "R4");
        send(16'hF0F0, 2, "R4");
        drain();
        idle_hold(1'b0);   // R8: last bit of F0F0 is 0

        // R9: odd divider, changed while a word is shifting
        div_ratio = 8'd3;
        send(16'h5A5A, 3, "R9");
        send(16'hC33C, 5, "R9");
        repeat (10) @(negedge clk);
        div_ratio = 8'd5;
        drain();

        // R4: divider values below 2 act as 2
        div_ratio = 8'd0;
        send(16'h9669, 2, "R4");
        send(16'h6996, 2, "R4");
        drain();
        div_ratio = 8'd1;
        send(16'h0001, 2, "R4");
        drain();

        chk(exp_bit_q.size() == 0, "R3", "all bits observed", int'(exp_bit_q.size()), 0);
        done_flag = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end

endmodule